// File: doc/BRIEF.md
# SPI Slave Shift Engine with Selectable Clock Format

This block is the serial side of an SPI target. An external controller supplies the serial clock, an active-low select and the controller-to-target data line. The block returns data on the target-to-controller line in the same cycle of the shift clock. It is used on every SPI link where the local device is the clocked party. Clock polarity, clock phase and character length (8 or 16 bits) are static configuration inputs. They are changed only while select is high.

All serial inputs are resampled by the local system clock through a short synchronizer chain, and clock edges are found in the system-clock domain. A 16-bit parallel buffer holds the word to send. The host loads it through a write strobe. When a character completes, the received word replaces the buffer contents and a one-cycle done strobe is raised in the same cycle. The outgoing data line carries an enable that follows the synchronized select.

Top module: `spi_slave_shifter`

## Requirements
- R1: With cfg_cpol=0 the clock idles low and its rising edge is the active edge. With cfg_cpol=1 it idles high and its falling edge is active.
- R2: With cfg_cpha=0 incoming data is sampled on active edges. With cfg_cpha=1 it is sampled on the edges that return the clock to idle. Outgoing data changes on the opposite edge type.
- R3: Transmission and reception are full duplex and MSB first. The controller reads the buffer word bit by bit on the data-out line while the block collects the controller's word.
- R4: With cfg_wide=0 a character is 8 bits. Bit 7 of the buffer goes out first, and bits 15:8 have no effect on the line. The received byte lands in bits 7:0 and bits 15:8 are cleared to zero.
- R5: With cfg_cpha=0 a character begins only when select falls. Clock edges that arrive after a completed character, while select stays low, neither strobe done nor alter the buffer.
- R6: With cfg_cpha=1 select may stay low across characters. The first active edge after a completed character starts the next one and takes the current buffer contents.
- R7: If select rises before the last bit of a character, the character is dropped. No done is produced, the buffer keeps its value, and the next selection starts from bit 0.
- R8: done is high for exactly one system clock per completed character, and it is high in the cycle the received word first appears on buf_q.
- R9: miso_oe is high only while the synchronized select is low. While miso_oe is low, miso is 0.
- R10: A buf_wr pulse places buf_wdata on buf_q from the next system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Clock idle level (0 low, 1 high) |
| cfg_cpha | input | 1 | Sampling edge (0 active edge, 1 return-to-idle edge) |
| cfg_wide | input | 1 | Character length (0 = 8 bits, 1 = 16 bits) |
| buf_wr | input | 1 | Host write strobe for the data buffer |
| buf_wdata | input | 16 | Host write data |
| buf_q | output | 16 | Current buffer contents |
| done | output | 1 | One-cycle character-complete strobe |
| sck | input | 1 | Serial clock from the controller |
| ssel_n | input | 1 | Active-low select from the controller |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for miso |

## Verification
The hardest states to reach from the ports are the ones where select stays low after a character has ended. In phase 0 the extra clock edges must be ignored. In phase 1 they must start a fresh character with a buffer word the host wrote between characters. The bench reaches both by holding select low after a completed character and issuing a further full character of clocks. In phase 1 it also writes a new word into the buffer in the gap. The abort case is reached by raising select after five bits. A full character then follows, so the bench can observe that no partial state was kept.

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_wide,
  input  logic              buf_wr,
  input  logic [WORD_W-1:0] buf_wdata,
  output logic [WORD_W-1:0] buf_q,
  output logic              done,
  input  logic              sck,
  input  logic              ssel_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe
);
  localparam int HALF_W = WORD_W / 2;
  localparam int CW     = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_WIDE = CW'(WORD_W - 1);
  localparam logic [CW-1:0] LAST_HALF = CW'(HALF_W - 1);

  logic [SYNC_STAGES-1:0] sck_sy, ssn_sy, mosi_sy;
  logic sck_q, sel_q, armed;
  logic [CW-1:0]       cnt;
  logic [WORD_W-2:0]   rx;
  logic [WORD_W-1:0]   tx;
  logic [WORD_W-1:0]   rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      ssn_sy  <= '1;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[SYNC_STAGES-2:0], sck};
      ssn_sy  <= {ssn_sy[SYNC_STAGES-2:0], ssel_n};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
    end
  end

  wire sck_s   = sck_sy[SYNC_STAGES-1];
  wire mosi_s  = mosi_sy[SYNC_STAGES-1];
  wire sel     = ~ssn_sy[SYNC_STAGES-1];
  wire sel_on  = sel & ~sel_q;
  wire rise    = sck_s & ~sck_q;
  wire fall    = ~sck_s & sck_q;
  wire act     = cfg_cpol ? fall : rise;
  wire ret     = cfg_cpol ? rise : fall;
  wire samp    = cfg_cpha ? ret : act;
  wire shft    = cfg_cpha ? act : ret;
  wire last    = cnt == (cfg_wide ? LAST_WIDE : LAST_HALF);
  wire live    = cfg_cpha | armed;

  assign rx_word = cfg_wide ? {rx, mosi_s}
                            : {{HALF_W{1'b0}}, rx[HALF_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
      rx    <= '0;
      tx    <= '0;
      buf_q <= '0;
      done  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel;
      done  <= 1'b0;
      if (buf_wr) buf_q <= buf_wdata;
      if (!sel) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (sel_on) begin
        cnt   <= '0;
        armed <= 1'b1;
        tx    <= buf_q;
      end else if (live) begin
        if (shft) tx <= (cfg_cpha && cnt == '0) ? buf_q : tx << 1;
        if (samp) begin
          rx <= {rx[WORD_W-3:0], mosi_s};
          if (last) begin
            cnt   <= '0;
            armed <= 1'b0;
            done  <= 1'b1;
            buf_q <= rx_word;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  assign miso_oe = sel;
  assign miso    = sel & (cfg_wide ? tx[WORD_W-1] : tx[HALF_W-1]);
endmodule

// File: rtl/spi_slave_shifter_chk.sv
module spi_slave_shifter_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wide,
  input logic              buf_wr,
  input logic [WORD_W-1:0] buf_q,
  input logic              done,
  input logic              miso,
  input logic              miso_oe
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> miso_oe);
  a_r8_buf_moves_only_on_done_or_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(buf_wr)) |-> $stable(buf_q));
  a_r4_narrow_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_wide) |-> buf_q[WORD_W-1:WORD_W/2] == '0);
  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);
endmodule

bind spi_slave_shifter spi_slave_shifter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .buf_wr(buf_wr),
  .buf_q(buf_q), .done(done), .miso(miso), .miso_oe(miso_oe));

// File: tb/tb_spi_slave_shifter.sv
module tb_spi_slave_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wide = 1'b1;
  logic buf_wr = 1'b0;
  logic [15:0] buf_wdata = '0;
  logic [15:0] buf_q;
  logic done, sck = 1'b0, ssel_n = 1'b1, mosi = 1'b0, miso, miso_oe;

  int n_chk = 0, n_bad = 0, n_done = 0, run = 0, max_run = 0;

  spi_slave_shifter dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_wide(cfg_wide), .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
    .done(done), .sck(sck), .ssel_n(ssel_n), .mosi(mosi), .miso(miso),
    .miso_oe(miso_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (done) begin
      n_done++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(logic [15:0] w);
    @(negedge clk); buf_wr = 1'b1; buf_wdata = w;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic set_mode(logic pol, logic pha, logic wide);
    cfg_cpol = pol; cfg_cpha = pha; cfg_wide = wide; sck = pol;
    idle(H);
  endtask

  task automatic shift_char(int nb, logic [15:0] mo, output logic [15:0] mi);
    mi = '0;
    if (!cfg_cpha) mosi = mo[nb-1];
    idle(H);
    for (int i = nb - 1; i >= 0; i--) begin
      sck = ~cfg_cpol;
      if (cfg_cpha) mosi = mo[i];
      else mi = {mi[14:0], miso};
      idle(H);
      sck = cfg_cpol;
      if (cfg_cpha) mi = {mi[14:0], miso};
      else if (i > 0) mosi = mo[i-1];
      idle(H);
    end
  endtask

  task automatic t_reset;
    check("R9 reset oe", {15'b0, miso_oe}, 16'h0);
    check("R9 reset miso", {15'b0, miso}, 16'h0);
    check("R8 reset done", {15'b0, done}, 16'h0);
    check("R10 reset buf", buf_q, 16'h0);
    host_write(16'hBEEF);
    check("R10 host write", buf_q, 16'hBEEF);
  endtask

  task automatic t_modes;
    logic [15:0] mi, tx, mo;
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0], 1'b1);
      tx = 16'h9A31 ^ 16'(m * 16'h1111);
      mo = 16'h5C87 + 16'(m * 16'h0203);
      host_write(tx);
      n_done = 0;
      ssel_n = 1'b0;
      shift_char(16, mo, mi);
      check("R1 R2 R3 controller receives buffer", mi, tx);
      check("R3 block receives controller word", buf_q, mo);
      check("R8 one done per character", 16'(n_done), 16'd1);
      ssel_n = 1'b1; idle(H);
    end
  endtask

  task automatic t_narrow;
    logic [15:0] mi;
    set_mode(1'b0, 1'b1, 1'b0);
    host_write(16'hA53C);
    ssel_n = 1'b0;
    shift_char(8, 16'h00C6, mi);
    check("R4 low byte sent, upper ignored", mi, 16'h003C);
    check("R4 byte right-justified, upper zero", buf_q, 16'h00C6);
    ssel_n = 1'b1; idle(H);
    set_mode(1'b1, 1'b0, 1'b0);
    host_write(16'hFF81);
    ssel_n = 1'b0;
    shift_char(8, 16'h007E, mi);
    check("R4 narrow mode pol1 pha0 tx", mi, 16'h0081);
    check("R4 narrow mode pol1 pha0 rx", buf_q, 16'h007E);
    ssel_n = 1'b1; idle(H);
  endtask

  task automatic t_pha0_hold;
    logic [15:0] mi;
    set_mode(1'b0, 1'b0, 1'b0);
    host_write(16'h0012);
    n_done = 0;
    ssel_n = 1'b0;
    shift_char(8, 16'h00A7, mi);
    check("R5 first character", buf_q, 16'h00A7);
    shift_char(8, 16'h0033, mi);
    check("R5 no done without reselect", 16'(n_done), 16'd1);
    check("R5 buffer kept without reselect", buf_q, 16'h00A7);
    ssel_n = 1'b1; idle(H);
    host_write(16'h0044);
    ssel_n = 1'b0;
    shift_char(8, 16'h0059, mi);
    check("R5 reselect starts new character", buf_q, 16'h0059);
    check("R5 reselect tx", mi, 16'h0044);
    ssel_n = 1'b1; idle(H);
  endtask

  task automatic t_pha1_b2b;
    logic [15:0] mi;
    set_mode(1'b1, 1'b1, 1'b1);
    host_write(16'h1357);
    n_done = 0;
    ssel_n = 1'b0;
    shift_char(16, 16'hCAFE, mi);
    check("R6 first character tx", mi, 16'h1357);
    check("R6 first character rx", buf_q, 16'hCAFE);
    host_write(16'h2468);
    shift_char(16, 16'h0F0F, mi);
    check("R6 second character takes new buffer", mi, 16'h2468);
    check("R6 second character rx", buf_q, 16'h0F0F);
    check("R6 two done strobes", 16'(n_done), 16'd2);
    ssel_n = 1'b1; idle(H);
  endtask

  task automatic t_abort;
    logic [15:0] mi;
    set_mode(1'b0, 1'b1, 1'b1);
    host_write(16'h7E11);
    n_done = 0;
    ssel_n = 1'b0;
    idle(H);
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; mosi = 1'b1; idle(H);
      sck = 1'b0; idle(H);
    end
    ssel_n = 1'b1; idle(H);
    check("R7 no done on abort", 16'(n_done), 16'd0);
    check("R7 buffer kept on abort", buf_q, 16'h7E11);
    check("R9 oe low after deselect", {15'b0, miso_oe}, 16'h0);
    check("R9 miso low after deselect", {15'b0, miso}, 16'h0);
    ssel_n = 1'b0;
    shift_char(16, 16'h8421, mi);
    check("R7 clean restart tx", mi, 16'h7E11);
    check("R7 clean restart rx", buf_q, 16'h8421);
    check("R9 oe high while selected", {15'b0, miso_oe}, 16'h1);
    ssel_n = 1'b1; idle(H);
    check("R8 done width", 16'(max_run), 16'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_modes;
    t_narrow;
    t_pha0_hold;
    t_pha1_b2b;
    t_abort;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule